// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block merges three reasons to reset a processor and turns them into one clean reset with a guaranteed minimum length. The reasons are a synchronous flag that says the supply is under its threshold, an active-low push-button input that may bounce or glitch, and a one-cycle timeout pulse from a watchdog. While the supply flag or the push-button holds, reset stays on. Once the last reason has gone, reset is held for a further recovery interval and then released. Any new reason that arrives during that interval starts it again from zero.

The recovery interval is a whole number of prescaled ticks. A free-running divider makes one tick every `TICK_DIV` clocks. The number of ticks is chosen by a two-bit code, which is captured each time the interval restarts. The push-button passes through a two-flop synchronizer and a persistence counter, so a short low glitch is ignored. The block drives an active-low reset, its active-high complement, and a level that tells the watchdog to keep its counter clear.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `reset_o` is 1. After `rst` falls with the supply flag clear, `reset_o` falls on the `TICK_DIV*N`-th clock edge after the first edge with `rst` low, where N is the tick count of the code sampled during reset.
- R2: While `supply_low_i` is 1 or the filtered push-button is held, `reset_o` stays 1 every cycle from the edge after the cause is first seen.
- R3: After `supply_low_i` returns to 0, `reset_o` falls on the `TICK_DIV*N`-th edge counted from the first edge at which no cause is present.
- R4: A one-cycle pulse on `wdog_expire_i` makes `reset_o` 1 from the next edge for exactly `TICK_DIV*N` cycles.
- R5: Any cause seen during the recovery interval restarts the interval from zero.
- R6: Code values on `interval_sel_i`: 0 selects `SHORT_TICKS`, 1 selects `MID_TICKS`, 2 selects `LONG_TICKS`, and 3 also selects `MID_TICKS`.
- R7: `reset_n_o` is the inverse of `reset_o` in every cycle.
- R8: A low on `button_n_i` counts only after it has been seen low for `GLITCH_CYCLES` consecutive edges after the two-flop synchronizer. A shorter low has no effect. After the button is released, `reset_o` stays 1 for `TICK_DIV*N+2` cycles, which includes the three-stage input latency.
- R9: The code is captured only at edges where a cause is present, or during reset. A change on `interval_sel_i` during the recovery interval does not change its length.
- R10: `reset_active_o` equals `reset_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_low_i | input | 1 | 1 while the supply is under its threshold |
| button_n_i | input | 1 | Asynchronous active-low push-button |
| wdog_expire_i | input | 1 | One-cycle watchdog timeout pulse |
| interval_sel_i | input | 2 | Recovery interval code |
| reset_n_o | output | 1 | Active-low processor reset |
| reset_o | output | 1 | Active-high processor reset |
| reset_active_o | output | 1 | Reset-in-progress level for the watchdog |

## Verification
The bench builds the block with `TICK_DIV=4`, tick counts 3, 5 and 7, and `GLITCH_CYCLES=4`. With these values every interval lasts 12 to 28 cycles. That makes it practical to measure the exact release edge for all four codes against each of the three causes, and to try every button pulse length from 1 cycle up to the filter threshold. The small sizes also leave room to restart an interval partway through and to change the code while an interval is running.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

    typedef enum logic [1:0] {
        IVL_SHORT = 2'd0,
        IVL_MID   = 2'd1,
        IVL_LONG  = 2'd2,
        IVL_ALT   = 2'd3
    } ivl_code_e;

    typedef struct packed {
        logic supply;
        logic button;
        logic wdog;
    } cause_t;

    function automatic int unsigned ivl_ticks(ivl_code_e code, int unsigned s,
                                              int unsigned m, int unsigned l);
        case (code)
            IVL_SHORT: return s;
            IVL_LONG:  return l;
            default:   return m;
        endcase
    endfunction

endpackage

// File: rtl/rsup_button_filter.sv
module rsup_button_filter #(
    parameter int GLITCH_CYCLES = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic button_n_i,
    output logic pressed_o
);
    localparam int GW = (GLITCH_CYCLES > 1) ? $clog2(GLITCH_CYCLES) : 1;
    localparam logic [GW-1:0] LAST = GW'(GLITCH_CYCLES - 1);

    logic          sync1, sync2;
    logic [GW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1     <= 1'b1;
            sync2     <= 1'b1;
            low_cnt   <= '0;
            pressed_o <= 1'b0;
        end else begin
            sync1 <= button_n_i;
            sync2 <= sync1;
            if (sync2) begin
                low_cnt   <= '0;
                pressed_o <= 1'b0;
            end else if (low_cnt == LAST) begin
                pressed_o <= 1'b1;
            end else begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsup_tick_gen.sv
module rsup_tick_gen #(
    parameter int TICK_DIV = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    output logic tick_o
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] WRAP = DW'(TICK_DIV - 1);

    logic [DW-1:0] div_cnt;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            div_cnt <= '0;
        end else if (div_cnt == WRAP) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tick_o = (div_cnt == WRAP) && !clr_i;
endmodule

// File: rtl/rsup_recovery_timer.sv
module rsup_recovery_timer
    import rst_sup_pkg::*;
#(
    parameter int SHORT_TICKS = 140,
    parameter int MID_TICKS   = 20000,
    parameter int LONG_TICKS  = 24000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart_i,
    input  ivl_code_e code_i,
    input  logic      tick_i,
    output logic      active_o
);
    localparam int MAXT = (LONG_TICKS > MID_TICKS)
                        ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
                        : ((MID_TICKS > SHORT_TICKS) ? MID_TICKS : SHORT_TICKS);
    localparam int TW = $clog2(MAXT + 1);

    logic [TW-1:0] tick_cnt;
    logic [TW-1:0] target;
    logic [TW-1:0] sel_ticks;

    assign sel_ticks = TW'(ivl_ticks(code_i, SHORT_TICKS, MID_TICKS, LONG_TICKS));

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            active_o <= 1'b1;
            tick_cnt <= '0;
            target   <= sel_ticks;
        end else if (active_o && tick_i) begin
            if (tick_cnt == target - 1'b1) begin
                active_o <= 1'b0;
                tick_cnt <= '0;
            end else begin
                tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rst_sup_pkg::*;
#(
    parameter int TICK_DIV      = 500,
    parameter int SHORT_TICKS   = 140,
    parameter int MID_TICKS     = 20000,
    parameter int LONG_TICKS    = 24000,
    parameter int GLITCH_CYCLES = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_low_i,
    input  logic       button_n_i,
    input  logic       wdog_expire_i,
    input  logic [1:0] interval_sel_i,
    output logic       reset_n_o,
    output logic       reset_o,
    output logic       reset_active_o
);
    cause_t cause;
    logic   pressed;
    logic   restart;
    logic   tick;
    logic   active;

    rsup_button_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_btn (
        .clk(clk), .rst(rst), .button_n_i(button_n_i), .pressed_o(pressed)
    );

    assign cause.supply = supply_low_i;
    assign cause.button = pressed;
    assign cause.wdog   = wdog_expire_i;
    assign restart      = |cause;

    rsup_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .clr_i(restart), .tick_o(tick)
    );

    rsup_recovery_timer #(
        .SHORT_TICKS(SHORT_TICKS), .MID_TICKS(MID_TICKS), .LONG_TICKS(LONG_TICKS)
    ) u_timer (
        .clk(clk), .rst(rst), .restart_i(restart),
        .code_i(ivl_code_e'(interval_sel_i)), .tick_i(tick), .active_o(active)
    );

    assign reset_o        = active;
    assign reset_n_o      = ~active;
    assign reset_active_o = active;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
    parameter int TICK_DIV    = 500,
    parameter int SHORT_TICKS = 140,
    parameter int MID_TICKS   = 20000,
    parameter int LONG_TICKS  = 24000
) (
    input logic clk,
    input logic rst,
    input logic supply_low_i,
    input logic wdog_expire_i,
    input logic reset_n_o,
    input logic reset_o,
    input logic reset_active_o
);
    localparam int MINT = (SHORT_TICKS < MID_TICKS)
                        ? ((SHORT_TICKS < LONG_TICKS) ? SHORT_TICKS : LONG_TICKS)
                        : ((MID_TICKS < LONG_TICKS) ? MID_TICKS : LONG_TICKS);
    localparam logic [31:0] MIN_HIGH = 32'(TICK_DIV * MINT);

    logic [31:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !reset_o) hi_cnt <= '0;
        else if (hi_cnt != 32'hFFFF_FFFF) hi_cnt <= hi_cnt + 1;
    end

    p_cplm_r7: assert property (@(posedge clk) disable iff (rst)
        reset_n_o == !reset_o);
    p_active_r10: assert property (@(posedge clk) disable iff (rst)
        reset_active_o == reset_o);
    p_supply_hold_r2: assert property (@(posedge clk) disable iff (rst)
        supply_low_i |=> reset_o);
    p_wdog_r4: assert property (@(posedge clk) disable iff (rst)
        wdog_expire_i |=> reset_o);
    p_min_width_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_o) |-> hi_cnt >= MIN_HIGH);
    p_no_early_release_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_o) |-> (!$past(supply_low_i) && !$past(wdog_expire_i)));
endmodule

bind rst_supervisor rst_supervisor_chk #(
    .TICK_DIV(TICK_DIV), .SHORT_TICKS(SHORT_TICKS),
    .MID_TICKS(MID_TICKS), .LONG_TICKS(LONG_TICKS)
) u_chk (
    .clk(clk), .rst(rst), .supply_low_i(supply_low_i),
    .wdog_expire_i(wdog_expire_i), .reset_n_o(reset_n_o),
    .reset_o(reset_o), .reset_active_o(reset_active_o)
);

// File: tb/rst_supervisor_bench.sv
`timescale 1ns/1ps
module rst_supervisor_bench;
    localparam int DIV = 4;
    localparam int TS  = 3;
    localparam int TM  = 5;
    localparam int TL  = 7;
    localparam int GL  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_low = 1'b0;
    logic       button_n = 1'b1;
    logic       wdog = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       reset_n, reset_h, reset_act;

    int checks = 0;
    int bad = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    rst_supervisor #(
        .TICK_DIV(DIV), .SHORT_TICKS(TS), .MID_TICKS(TM),
        .LONG_TICKS(TL), .GLITCH_CYCLES(GL)
    ) u_rst_supervisor (
        .clk(clk), .rst(rst), .supply_low_i(supply_low), .button_n_i(button_n),
        .wdog_expire_i(wdog), .interval_sel_i(sel), .reset_n_o(reset_n),
        .reset_o(reset_h), .reset_active_o(reset_act)
    );

    function automatic int exp_len(int code);
        case (code)
            0: return DIV * TS;
            2: return DIV * TL;
            default: return DIV * TM;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // counts samples with reset high until it drops; also checks R7/R10 each sample
    task automatic measure(output int cnt);
        bit side_ok = 1'b1;
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (reset_n !== ~reset_h || reset_act !== reset_h) side_ok = 1'b0;
            if (reset_h !== 1'b1) break;
            cnt++;
        end
        check(side_ok, "R7/R10 complement and active level", int'(side_ok), 1);
    endtask

    initial begin
        int n;
        // R1 reset state
        step(3);
        check(reset_h === 1'b1 && reset_n === 1'b0, "R1 asserted during reset",
              int'(reset_h), 1);
        check(reset_act === 1'b1, "R10 active during reset", int'(reset_act), 1);
        sel = 2'd0;
        rst = 1'b0;
        measure(n);
        check(n == exp_len(0) - 1, "R1 power-on interval", n, exp_len(0) - 1);
        step(20);
        check(reset_h === 1'b0 && reset_n === 1'b1, "R1 idle released",
              int'(reset_h), 0);

        for (int code = 0; code < 4; code++) begin
            sel = 2'(code);
            // supply cause
            supply_low = 1'b1;
            step(5);
            check(reset_h === 1'b1, "R2 held by supply flag", int'(reset_h), 1);
            supply_low = 1'b0;
            measure(n);
            check(n == exp_len(code) - 1, "R3/R6 supply release length",
                  n, exp_len(code) - 1);
            step(3);
            // watchdog cause
            wdog = 1'b1;
            @(posedge clk);
            @(negedge clk);
            wdog = 1'b0;
            n = (reset_h === 1'b1) ? 1 : 0;
            begin
                int m;
                measure(m);
                n += m;
            end
            check(n == exp_len(code), "R4/R6 watchdog pulse length", n, exp_len(code));
            step(3);
            // button cause
            button_n = 1'b0;
            step(10);
            check(reset_h === 1'b1, "R2 held by button", int'(reset_h), 1);
            button_n = 1'b1;
            measure(n);
            check(n == exp_len(code) + 2, "R8/R6 button release length",
                  n, exp_len(code) + 2);
            step(3);
        end

        // R8 glitch sweep
        sel = 2'd0;
        for (int len = 1; len < GL; len++) begin
            int seen = 0;
            button_n = 1'b0;
            step(len);
            button_n = 1'b1;
            for (int i = 0; i < 10; i++) begin
                step(1);
                if (reset_h === 1'b1) seen++;
            end
            check(seen == 0, "R8 short low ignored", seen, 0);
        end
        button_n = 1'b0;
        step(GL);
        button_n = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                step(1);
                if (reset_h === 1'b1) seen++;
            end
            check(seen > 0, "R8 threshold-length low accepted", seen, 1);
        end
        step(40);

        // R5 restart mid-interval
        sel = 2'd1;
        wdog = 1'b1;
        step(1);
        wdog = 1'b0;
        step(7);
        supply_low = 1'b1;
        step(1);
        supply_low = 1'b0;
        measure(n);
        check(n == exp_len(1) - 1, "R5 supply restart", n, exp_len(1) - 1);
        step(3);
        sel = 2'd0;
        wdog = 1'b1;
        step(1);
        wdog = 1'b0;
        step(5);
        wdog = 1'b1;
        step(1);
        wdog = 1'b0;
        measure(n);
        check(n == exp_len(0) - 1, "R5 watchdog restart", n, exp_len(0) - 1);
        step(3);

        // R9 code change during interval ignored
        sel = 2'd2;
        supply_low = 1'b1;
        step(3);
        supply_low = 1'b0;
        sel = 2'd0;
        measure(n);
        check(n == exp_len(2) - 1, "R9 code latched at restart", n, exp_len(2) - 1);
        sel = 2'd0;
        supply_low = 1'b1;
        step(3);
        supply_low = 1'b0;
        sel = 2'd2;
        measure(n);
        check(n == exp_len(0) - 1, "R9 code latched short", n, exp_len(0) - 1);

        step(5);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule